// File: doc/BRIEF.md
# Minute-Resolution Alarm Match Unit

This block compares the running calendar of a real-time clock against a programmed alarm time. It holds four alarm fields: minute, hour, day of month and day of week. Each is a BCD value with its own disable bit. When the calendar signals that a new minute has begun, the unit checks the enabled fields. If all of them match, it raises a sticky alarm flag. Seconds take no part in the match, so the alarm has one-minute resolution.

The flag and an interrupt enable live in a shared control byte. An active-low, level-type interrupt pin is driven low while both are set. Software clears the flag by writing a zero to its bit, which releases the pin. Setting the flag is reserved to the hardware.

The flag is held by a two-state machine:

- States: `AF_IDLE` (no alarm pending) and `AF_RAISED` (alarm pending).
- Transition *match*: `AF_IDLE` to `AF_RAISED` on a minute strobe with every enabled field equal.
- Transition *host clear*: `AF_RAISED` to `AF_IDLE` on a control write with the flag bit at 0, provided no match arrives in the same cycle.
- All other cycles hold the current state.

Top module: `minute_alarm_unit`

## Requirements
- R1: After reset, `irq_n` is 1. Control address 0x1 reads 0x00 and each alarm address 0x9 to 0xC reads 0x80, so every field starts disabled.
- R2: A write to an alarm address stores the full byte and reads back unchanged. Address 0x9 holds the minute, 0xA the hour, 0xB the day and 0xC the weekday. Bit 7 of each is the field's disable bit.
- R3: Matching happens only on a cycle with `min_tick` high. Calendar values that equal the alarm without a strobe leave the flag clear.
- R4: On a strobe where every enabled field equals the calendar, the flag reads 1 from the next cycle on. The compared bits are minute [6:0], hour [5:0], day [5:0] and weekday [2:0]; other alarm bits below bit 7 are ignored.
- R5: A field whose bit 7 is 1 counts as matching whatever the calendar value.
- R6: With all four fields disabled, a strobe never sets the flag.
- R7: A write to control address 0x1 with bit 3 at 0 clears the flag. A write with bit 3 at 1 leaves it unchanged and never sets it.
- R8: The flag is set on a match even when the interrupt enable (control bit 1) is 0. `irq_n` is 0 exactly while the flag and the enable are both 1.
- R9: If a clearing write and a matching strobe fall in the same cycle, the flag is 1 afterwards.
- R10: Once set, the flag stays 1 through later strobes, matching or not, until a clearing write.
- R11: Control address 0x1 reads the flag at bit 3 and the enable at bit 1, with all other bits 0. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cal_min | input | 7 | Current minute, BCD |
| cal_hour | input | 6 | Current hour, BCD |
| cal_day | input | 6 | Current day of month, BCD |
| cal_wday | input | 3 | Current weekday |
| min_tick | input | 1 | One-cycle strobe when seconds wrap to 00 |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The embedded properties watch the flag machine on every cycle:

- a rise of the flag only after a qualified strobe;
- a set on every qualified strobe;
- the flag held until a clearing write;
- release on a clear that has no competing match;
- the pin kept high whenever the enable is off;
- no hit while every field is disabled.

Only the bench scenarios can show that the field masks, the BCD equality and the disable bits give the right match verdict for concrete alarm settings. The same holds for read-back of the registers and the exact cycle at which `irq_n` moves.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 4;
    localparam int NUM_FIELDS = 4;
    localparam int MIN_W      = 7;
    localparam int HOUR_W     = 6;
    localparam int DAY_W      = 6;
    localparam int WDAY_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_FIELD = 4'h9;   // first alarm field, others follow

    localparam int FLAG_BIT = 3;
    localparam int IEN_BIT  = 1;
    localparam int DIS_BIT  = 7;

    localparam logic [REG_W-1:0] FIELD_RESET = 8'h80;

    typedef enum logic [0:0] {
        AF_IDLE   = 1'b0,
        AF_RAISED = 1'b1
    } af_state_t;

    // significant-bit mask of alarm field idx (0 min, 1 hour, 2 day, 3 weekday)
    function automatic logic [REG_W-1:0] field_mask(input int idx);
        int w;
        case (idx)
            0:       w = MIN_W;
            1:       w = HOUR_W;
            2:       w = DAY_W;
            default: w = WDAY_W;
        endcase
        return REG_W'((1 << w) - 1);
    endfunction

endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
    import alm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        we_i,
    input  logic [REG_W-1:0]            wdata_i,
    input  logic                        flag_i,
    output logic [REG_W-1:0]            rdata_o,
    output logic [NUM_FIELDS*REG_W-1:0] fields_o,
    output logic                        ien_o,
    output logic                        clr_o
);

    logic [REG_W-1:0] field_q [NUM_FIELDS];
    logic             ctrl_wr;

    assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
    assign clr_o   = ctrl_wr && !wdata_i[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n)       ien_o <= 1'b0;
        else if (ctrl_wr) ien_o <= wdata_i[IEN_BIT];
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q[i] <= FIELD_RESET;
            else if (we_i && (addr_i == ADDR_W'(ADDR_FIELD + i)))
                field_q[i] <= wdata_i;
        end
        assign fields_o[i*REG_W +: REG_W] = field_q[i];
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o[FLAG_BIT] = flag_i;
            rdata_o[IEN_BIT]  = ien_o;
        end
        for (int k = 0; k < NUM_FIELDS; k++)
            if (addr_i == ADDR_W'(ADDR_FIELD + k)) rdata_o = field_q[k];
    end

endmodule

// File: rtl/alm_compare.sv
module alm_compare
    import alm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FIELDS*REG_W-1:0] fields_i,
    input  logic [NUM_FIELDS*REG_W-1:0] cal_i,
    output logic                        hit_o
);

    logic [NUM_FIELDS-1:0] en;
    logic [NUM_FIELDS-1:0] eq;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        localparam logic [REG_W-1:0] MASK = field_mask(i);
        logic [REG_W-1:0] fld;
        assign fld   = fields_i[i*REG_W +: REG_W];
        assign en[i] = !fld[DIS_BIT];
        assign eq[i] = ((fld & MASK) == (cal_i[i*REG_W +: REG_W] & MASK));
    end

    assign hit_o = (|en) && (&(eq | ~en));

    // R6: no field enabled means no hit
    p_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !hit_o);

endmodule

// File: rtl/alm_flag_fsm.sv
module alm_flag_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hit_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_n_o
);

    af_state_t state_q, state_d;
    logic      set_req;

    assign set_req = tick_i && hit_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AF_IDLE:   if (set_req)          state_d = AF_RAISED;
            AF_RAISED: if (clr_i && !set_req) state_d = AF_IDLE;
            default:                          state_d = AF_IDLE;
        endcase
    end

    always_comb begin
        flag_o  = (state_q == AF_RAISED);
        irq_n_o = !(flag_o && ien_i);
    end

    p_rise_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i && hit_i));

    p_set_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i) |=> flag_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(tick_i && hit_i)) |=> !flag_o);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/minute_alarm_unit.sv
module minute_alarm_unit
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [MIN_W-1:0]  cal_min,
    input  logic [HOUR_W-1:0] cal_hour,
    input  logic [DAY_W-1:0]  cal_day,
    input  logic [WDAY_W-1:0] cal_wday,
    input  logic              min_tick,
    output logic              irq_n
);

    logic [NUM_FIELDS*REG_W-1:0] fields;
    logic [NUM_FIELDS*REG_W-1:0] cal_vec;
    logic                        ien, clr, hit, flag;

    assign cal_vec = {REG_W'(cal_wday), REG_W'(cal_day),
                      REG_W'(cal_hour), REG_W'(cal_min)};

    alm_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .flag_i   (flag),
        .rdata_o  (bus_rdata),
        .fields_o (fields),
        .ien_o    (ien),
        .clr_o    (clr)
    );

    alm_compare u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fields_i (fields),
        .cal_i    (cal_vec),
        .hit_o    (hit)
    );

    alm_flag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (min_tick),
        .hit_i   (hit),
        .clr_i   (clr),
        .ien_i   (ien),
        .flag_o  (flag),
        .irq_n_o (irq_n)
    );

    // R8: pin stays released whenever the enable is off
    p_pin_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> irq_n);

endmodule

// File: tb/sim_minute_alarm_unit.sv
module sim_minute_alarm_unit;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] cal_min = '0;
    logic [5:0] cal_hour = '0;
    logic [5:0] cal_day = '0;
    logic [2:0] cal_wday = '0;
    logic       min_tick = 1'b0;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    minute_alarm_unit u0 (.*);

    // alarm min,hour,day,wday | cal min,hour,day,wday | expected flag
    localparam logic [54:0] VEC [NVEC] = '{
        {8'h30, 8'h12, 8'h15, 8'h03, 7'h30, 6'h12, 6'h15, 3'd3, 1'b1},
        {8'h30, 8'h12, 8'h15, 8'h03, 7'h31, 6'h12, 6'h15, 3'd3, 1'b0},
        {8'h45, 8'h89, 8'h20, 8'h01, 7'h45, 6'h23, 6'h20, 3'd1, 1'b1},
        {8'h80, 8'h80, 8'h80, 8'h80, 7'h00, 6'h00, 6'h00, 3'd0, 1'b0},
        {8'h80, 8'h80, 8'h80, 8'h05, 7'h59, 6'h07, 6'h31, 3'd5, 1'b1},
        {8'h80, 8'h80, 8'h80, 8'h05, 7'h59, 6'h07, 6'h31, 3'd4, 1'b0},
        {8'h00, 8'h52, 8'h80, 8'h80, 7'h00, 6'h12, 6'h01, 3'd2, 1'b1},
        {8'h10, 8'h08, 8'h28, 8'h80, 7'h10, 6'h08, 6'h27, 3'd6, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
    endtask

    task automatic set_cal(input logic [6:0] m, input logic [5:0] h,
                           input logic [5:0] d, input logic [2:0] w);
        cal_min = m; cal_hour = h; cal_day = d; cal_wday = w;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        rd(4'h1, r); check("R1 ctrl", r, 8'h00);
        for (int a = 9; a <= 12; a++) begin
            rd(4'(a), r); check("R1 field", r, 8'h80);
        end

        // R2 readback
        wr(4'h9, 8'h59); wr(4'hA, 8'hA3); wr(4'hB, 8'h31); wr(4'hC, 8'h86);
        rd(4'h9, r); check("R2 min", r, 8'h59);
        rd(4'hA, r); check("R2 hour", r, 8'hA3);
        rd(4'hB, r); check("R2 day", r, 8'h31);
        rd(4'hC, r); check("R2 wday", r, 8'h86);
        rd(4'h5, r); check("R11 unmapped", r, 8'h00);

        // table walk: R4 R5 R6 and masking
        for (int v = 0; v < NVEC; v++) begin
            wr(4'h9, VEC[v][54:47]); wr(4'hA, VEC[v][46:39]);
            wr(4'hB, VEC[v][38:31]); wr(4'hC, VEC[v][30:23]);
            wr(4'h1, 8'h00);
            set_cal(VEC[v][22:16], VEC[v][15:10], VEC[v][9:4], VEC[v][3:1]);
            tick();
            rd(4'h1, r); check("R4/R5/R6 vector", r, {4'b0, VEC[v][0], 3'b0});
        end

        // R3 match without strobe
        wr(4'h9, 8'h30); wr(4'hA, 8'h12); wr(4'hB, 8'h15); wr(4'hC, 8'h03);
        wr(4'h1, 8'h00);
        set_cal(7'h30, 6'h12, 6'h15, 3'd3);
        repeat (4) @(negedge clk);
        rd(4'h1, r); check("R3 no tick", r, 8'h00);

        // R8 flag with enable off, pin stays high
        tick();
        rd(4'h1, r); check("R8 flag without enable", r, 8'h08);
        check("R8 pin idle", {7'b0, irq_n}, 8'h01);
        // enable: write 1 to flag bit keeps flag (R7) and turns pin on
        wr(4'h1, 8'h0A);
        #1 check("R8 pin low", {7'b0, irq_n}, 8'h00);
        rd(4'h1, r); check("R11 ctrl bits", r, 8'h0A);

        // R10 sticky across mismatching strobe
        set_cal(7'h31, 6'h12, 6'h15, 3'd3);
        tick();
        rd(4'h1, r); check("R10 sticky", r, 8'h0A);

        // R7 clear
        wr(4'h1, 8'h02);
        #1 check("R7 pin released", {7'b0, irq_n}, 8'h01);
        rd(4'h1, r); check("R7 cleared", r, 8'h02);

        // R7 writing 1 never sets
        wr(4'h1, 8'h0A);
        rd(4'h1, r); check("R7 set by write ignored", r, 8'h02);

        // R9 simultaneous clear and match
        set_cal(7'h30, 6'h12, 6'h15, 3'd3);
        @(negedge clk);
        bus_addr = 4'h1; bus_we = 1'b1; bus_wdata = 8'h02; min_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; min_tick = 1'b0;
        rd(4'h1, r); check("R9 set wins", r, 8'h0A);
        #1 check("R9 pin low", {7'b0, irq_n}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule